// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block gathers single-cycle event pulses from a storage-card host controller and turns them into one interrupt line. Each event has a fixed bit in a 32-bit status word. Normal events (command done, transfer done, block gap, buffer ready in each direction, card inserted, card removed, card-side interrupt) use the low half. Error events (command timeout, command CRC, command end bit, command index, data CRC) use the high half. An event is latched only when its status-enable bit is set. A latched bit stays set until software writes 1 to it.

A second mask, the signal-enable word, selects which latched bits may raise the interrupt output. The interrupt output is registered. Software reads and writes the three words through a small word-addressed port that has a combinational read. Bit 15 of the status word is a read-only summary that is 1 whenever any error status bit is set.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous reset, all three registers read as 0 and `irq_o` is 0.
- R2: With its status-enable bit at 1, a pulse on `evt_i` latches status bit 0 (command done), 1 (transfer done), 2 (block gap), 4 (write buffer ready), 5 (read buffer ready), 6 (card inserted), 7 (card removed) or 8 (card interrupt).
- R3: With its status-enable bit at 1, a pulse on `evt_i` latches status bit 16 (command timeout), 17 (command CRC), 18 (command end bit), 19 (command index) or 21 (data CRC).
- R4: An event whose status-enable bit is 0 is not latched. Setting that enable bit later does not latch it either.
- R5: A latched bit stays set after its event pulse ends, until it is cleared.
- R6: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: If an enabled event and a clearing write hit the same bit in the same cycle, the bit is set afterwards.
- R8: Reserved bits read as 0 and ignore writes and events. In the status word these are bits 3, 9–14, 20 and 22–31. In both enable words they are the same bits plus bit 15.
- R9: Status bit 15 reads 1 exactly when any of status bits 16–19 or 21 is set. Writes to bit 15 have no effect.
- R10: `irq_o` is the OR of all status bits that are also signal-enabled, registered one cycle after the status word changes.
- R11: A latched bit whose signal-enable bit is 0 does not raise `irq_o`, and the bit remains readable in the status word.
- R12: The register addresses are: `reg_addr` 0 selects status, 1 selects status-enable, 2 selects signal-enable. Address 3 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 32 | Event pulses, one per status bit position |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench drives an event and a write-1 clear onto the same bit in the same cycle. A design that gives the clear priority would lose that event, and the bit would read 0. It drives every event line while all enables are set and compares the status word with the exact legal pattern. A design that latches reserved holes, or that fails to compute bit 15 from the error bits, would show stray or missing bits there. It measures the interrupt output cycle by cycle after an event and after a clear. A combinational output would change one cycle early, and a design that ignores the signal-enable mask would raise the line for a masked bit. It also pulses an event while its status-enable bit is off and then turns the enable on. A design that stores unqualified events would then show the bit.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int REG_W = 32;
    localparam int SUMMARY_BIT = 15;

    localparam logic [REG_W-1:0] NORM_BITS  = 32'h0000_01F7;
    localparam logic [REG_W-1:0] ERR_BITS   = 32'h002F_0000;
    localparam logic [REG_W-1:0] LATCH_BITS = NORM_BITS | ERR_BITS;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_STS_EN = 2'd1,
        SEL_SIG_EN = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        reg_sel_e         sel;
        logic [REG_W-1:0] data;
    } reg_cmd_t;

    function automatic logic [REG_W-1:0] add_summary(input logic [REG_W-1:0] s);
        logic [REG_W-1:0] r;
        r = s & LATCH_BITS;
        r[SUMMARY_BIT] = |(s & ERR_BITS);
        return r;
    endfunction

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_pkg::*;
#(
    parameter logic [REG_W-1:0] KEEP = LATCH_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata & KEEP;
        end
    end

    // R8
    reserved_mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (q & ~KEEP) == '0);

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt,
    input  logic [REG_W-1:0] sts_en,
    input  logic             clr_we,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] status_q
);

    logic [REG_W-1:0] hit;
    logic [REG_W-1:0] clr;
    logic [REG_W-1:0] status_d;

    always_comb begin
        hit = evt & sts_en & LATCH_BITS;
        clr = clr_we ? clr_data : '0;
        status_d = (hit | (status_q & ~clr)) & LATCH_BITS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    // R7
    event_latches_chk: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt & sts_en)) == '0));

endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] status,
    input  logic [REG_W-1:0] sig_en,
    output logic             irq
);

    logic [REG_W-1:0] live;

    always_comb live = status & sig_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |live;
        end
    end

    // R10
    irq_latency_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(status & sig_en))));

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ((status & sig_en) == '0) |=> !irq);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  evt_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o
);

    localparam int SEL_W = 2;

    reg_cmd_t         cmd;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] sts_en_q;
    logic [REG_W-1:0] sig_en_q;

    generate
        if (ADDR_W > SEL_W) begin : g_wide
            always_comb begin
                cmd.wr   = reg_we;
                cmd.data = reg_wdata;
                if (reg_addr[ADDR_W-1:SEL_W] != '0) begin
                    cmd.sel = SEL_NONE;
                end else begin
                    cmd.sel = reg_sel_e'(reg_addr[SEL_W-1:0]);
                end
            end
        end else begin : g_narrow
            always_comb begin
                cmd.wr   = reg_we;
                cmd.data = reg_wdata;
                cmd.sel  = reg_sel_e'(SEL_W'(reg_addr));
            end
        end
    endgenerate

    irq_status_bank u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_i),
        .sts_en   (sts_en_q),
        .clr_we   (cmd.wr && cmd.sel == SEL_STATUS),
        .clr_data (cmd.data),
        .status_q (status_q)
    );

    irq_mask_reg #(.KEEP(LATCH_BITS)) u_sts_en (
        .clk   (clk),
        .rst   (rst),
        .we    (cmd.wr && cmd.sel == SEL_STS_EN),
        .wdata (cmd.data),
        .q     (sts_en_q)
    );

    irq_mask_reg #(.KEEP(LATCH_BITS)) u_sig_en (
        .clk   (clk),
        .rst   (rst),
        .we    (cmd.wr && cmd.sel == SEL_SIG_EN),
        .wdata (cmd.data),
        .q     (sig_en_q)
    );

    irq_out_reg u_out (
        .clk    (clk),
        .rst    (rst),
        .status (status_q),
        .sig_en (sig_en_q),
        .irq    (irq_o)
    );

    always_comb begin
        unique case (cmd.sel)
            SEL_STATUS: reg_rdata = add_summary(status_q);
            SEL_STS_EN: reg_rdata = sts_en_q;
            SEL_SIG_EN: reg_rdata = sig_en_q;
            default:    reg_rdata = '0;
        endcase
    end

    // R9
    summary_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.sel == SEL_STATUS) |-> (reg_rdata[SUMMARY_BIT] == ((status_q & ERR_BITS) != '0)));

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.sel == SEL_NONE) |-> (reg_rdata == '0));

endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt = '0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;

    localparam logic [31:0] LEGAL = 32'h002F_01F7;
    localparam logic [31:0] FULL_STATUS = 32'h002F_81F7;

    always #2 clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .reg_we    (we),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 status", v, 32'h0);
        rd(2'd1, v); check("R1 sts_en", v, 32'h0);
        rd(2'd2, v); check("R1 sig_en", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R8 R12 sts_en readback", v, LEGAL);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R8 R12 sig_en readback", v, LEGAL);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); check("R12 addr3 reads 0", v, 32'h0);
        rd(2'd1, v); check("R12 addr3 write ignored", v, LEGAL);
        wr(2'd2, 32'h0);
        rd(2'd0, v); check("R12 status untouched", v, 32'h0);
    endtask

    task automatic t_normal();
        logic [31:0] v;
        int positions[8] = '{0, 1, 2, 4, 5, 6, 7, 8};
        for (int i = 0; i < 8; i++) begin
            pulse(32'h1 << positions[i]);
            rd(2'd0, v); check($sformatf("R2 R5 bit %0d", positions[i]), v, 32'h1 << positions[i]);
            wr(2'd0, 32'h1 << positions[i]);
            rd(2'd0, v); check($sformatf("R6 clear bit %0d", positions[i]), v, 32'h0);
        end
    endtask

    task automatic t_error();
        logic [31:0] v;
        int positions[5] = '{16, 17, 18, 19, 21};
        for (int i = 0; i < 5; i++) begin
            pulse(32'h1 << positions[i]);
            rd(2'd0, v);
            check($sformatf("R3 R9 bit %0d", positions[i]), v, (32'h1 << positions[i]) | 32'h8000);
            wr(2'd0, 32'h1 << positions[i]);
            rd(2'd0, v); check($sformatf("R6 R9 clear bit %0d", positions[i]), v, 32'h0);
        end
    endtask

    task automatic t_gating();
        logic [31:0] v;
        wr(2'd1, 32'h0);
        pulse(32'hFFFF_FFFF);
        rd(2'd0, v); check("R4 disabled events", v, 32'h0);
        wr(2'd1, 32'h0000_0022);
        rd(2'd0, v); check("R4 late enable", v, 32'h0);
        pulse(32'h0000_0023);
        rd(2'd0, v); check("R4 partial enable", v, 32'h0000_0022);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        pulse(32'hFFFF_FFFF);
        rd(2'd0, v); check("R8 R9 all events", v, FULL_STATUS);
        wr(2'd0, 32'h0000_8000);
        rd(2'd0, v); check("R9 summary not writable", v, FULL_STATUS);
        wr(2'd0, 32'h0000_0001);
        rd(2'd0, v); check("R6 clear one only", v, FULL_STATUS & ~32'h1);
        wr(2'd0, 32'h002F_0000);
        rd(2'd0, v); check("R9 summary drops", v, 32'h0000_01F6);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R6 clear all", v, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        pulse(32'h0000_0001);
        @(negedge clk);
        we = 1'b1; addr = 2'd0; wdata = 32'h0000_0003; evt = 32'h0000_0002;
        @(negedge clk);
        we = 1'b0; wdata = '0; evt = '0;
        rd(2'd0, v); check("R7 event beats clear", v, 32'h0000_0002);
        wr(2'd0, 32'h0000_0002);
        rd(2'd0, v); check("R7 later clear", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(2'd2, 32'h0);
        pulse(32'h0000_0020);
        @(negedge clk);
        rd(2'd0, v); check("R11 status kept", v, 32'h0000_0020);
        check("R11 masked irq", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h0000_0020);
        check("R10 irq after sig_en write", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R10 irq one cycle later", {31'b0, irq}, 32'h1);
        @(negedge clk);
        we = 1'b1; addr = 2'd0; wdata = 32'h0000_0020;
        @(negedge clk);
        we = 1'b0; wdata = '0;
        check("R10 irq lags clear", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R10 irq falls", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h0020_0000);
        pulse(32'h0020_0000);
        check("R10 error irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R10 error irq", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0020_0000);
        @(negedge clk);
        check("R10 error irq cleared", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_normal();
        t_error();
        t_gating();
        t_reserved();
        t_race();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule